// File: doc/BRIEF.md
# Look-Ahead XY Route Unit

This block is the route stage of a mesh router input port that works one hop ahead. A flit that arrives here already carries, in its next-port field, the output direction this router will use. The unit turns that direction and the router's own coordinates into the address of the router the flit enters next. It then runs dimension-order routing for that downstream router and writes the result back into the next-port field. The downstream router can therefore start switch arbitration on arrival, without a route calculation first.

The mesh defaults to 4x4 with 3-bit coordinates. A build-time option adds a sixth direction for one long-distance link. Its two end routers and the set of destinations it serves are parameters. The next-port field then grows from five to six bits, and the flit grows by one bit. The result is registered, so it lands in the same pipeline stage as switch arbitration.

Flit layout (bit 0 first): destination Y in [2:0], destination X in [5:3], the one-hot next-port field from bit 6 up, then the payload, then the tail bit at the top.

Top module: `lar_route_unit`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `out_flit` is all zero.
- R2: A flit presented with `in_valid` high at a rising edge shows up on `out_flit` with `out_valid` high after that edge. It has the same destination, payload and tail bits; only the next-port field is rewritten.
- R3: The next-port field is one-hot, with bit 0 Local, bit 1 North, bit 2 East, bit 3 South, bit 4 West and (with the link option) bit 5 the long link. Every output flit carries exactly one set bit.
- R4: The downstream router is found from the incoming direction. North adds 1 to Y, South subtracts 1 from Y, East adds 1 to X, West subtracts 1 from X, and the long link gives the link's far-end coordinates.
- R5: X is corrected first. East is chosen when the destination X is above the downstream X, and West when it is below.
- R6: Once X matches, North is chosen when the destination Y is above the downstream Y, and South when it is below.
- R7: Local is chosen when the destination equals the downstream router's address.
- R8: When the downstream router is the link's near end and the destination is in the link's served set, the long-link direction (bit 5) is chosen instead of the XY result.
- R9: A destination outside the served set, or any downstream router other than the near end, gets the plain XY result.
- R10: A flit whose incoming next-port is Local leaves with next-port Local.
- R11: While `in_valid` is low, `out_flit` keeps its last value and `out_valid` is 0 one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| my_x | input | COORD_W | X coordinate of this router |
| my_y | input | COORD_W | Y coordinate of this router |
| in_valid | input | 1 | Incoming flit is valid |
| in_flit | input | FLIT_W | Incoming flit, next-port as used by this router |
| out_valid | output | 1 | Registered flit is valid |
| out_flit | output | FLIT_W | Flit with next-port for the downstream router |

## Verification
Every result is due exactly one rising edge after the flit is presented, because the path holds one register stage. The bench drives inputs on the falling edge and reads the outputs on the next falling edge, which falls half a period after the capturing edge. Flits sent back to back are each checked on the falling edge after their own capture. The hold behaviour is checked several falling edges into an idle stretch, with the input flit changed in between.

// File: rtl/lar_pkg.sv
package lar_pkg;
  // one-hot bit index of each direction in the next-port field
  localparam int unsigned DIR_LOCAL = 0;
  localparam int unsigned DIR_NORTH = 1;
  localparam int unsigned DIR_EAST  = 2;
  localparam int unsigned DIR_SOUTH = 3;
  localparam int unsigned DIR_WEST  = 4;
  localparam int unsigned DIR_LINK  = 5;
  localparam int unsigned DIR_IDX_W = 3;

  typedef logic [DIR_IDX_W-1:0] dir_idx_t;
endpackage

// File: rtl/lar_next_hop.sv
module lar_next_hop #(
  parameter int unsigned COORD_W = 3,
  parameter int unsigned NP_W    = 6,
  parameter bit          LINK_EN = 1'b1,
  parameter int unsigned FAR_X   = 3,
  parameter int unsigned FAR_Y   = 3
) (
  input  logic [COORD_W-1:0] cur_x,
  input  logic [COORD_W-1:0] cur_y,
  input  logic [NP_W-1:0]    port_in,
  output logic [COORD_W-1:0] hop_x,
  output logic [COORD_W-1:0] hop_y,
  output logic               hop_is_local
);
  import lar_pkg::*;

  localparam logic [COORD_W-1:0] ONE = COORD_W'(1);

  logic via_link;

  if (LINK_EN) begin : g_link
    assign via_link = port_in[NP_W-1];
  end else begin : g_nolink
    assign via_link = 1'b0;
  end

  // lowest set bit wins; an empty field is treated as a delivered flit
  always_comb begin
    hop_x        = cur_x;
    hop_y        = cur_y;
    hop_is_local = 1'b0;
    if (port_in[DIR_LOCAL]) begin
      hop_is_local = 1'b1;
    end else if (port_in[DIR_NORTH]) begin
      hop_y = cur_y + ONE;
    end else if (port_in[DIR_EAST]) begin
      hop_x = cur_x + ONE;
    end else if (port_in[DIR_SOUTH]) begin
      hop_y = cur_y - ONE;
    end else if (port_in[DIR_WEST]) begin
      hop_x = cur_x - ONE;
    end else if (via_link) begin
      hop_x = COORD_W'(FAR_X);
      hop_y = COORD_W'(FAR_Y);
    end else begin
      hop_is_local = 1'b1;
    end
  end
endmodule

// File: rtl/lar_xy_pick.sv
module lar_xy_pick #(
  parameter int unsigned COORD_W   = 3,
  parameter int unsigned NP_W      = 6,
  parameter int unsigned MESH_X    = 4,
  parameter int unsigned MESH_Y    = 4,
  parameter bit          LINK_EN   = 1'b1,
  parameter int unsigned NEAR_X    = 0,
  parameter int unsigned NEAR_Y    = 0,
  parameter logic [MESH_X*MESH_Y-1:0] SERVED = '0
) (
  input  logic [COORD_W-1:0] hop_x,
  input  logic [COORD_W-1:0] hop_y,
  input  logic               hop_is_local,
  input  logic [COORD_W-1:0] dst_x,
  input  logic [COORD_W-1:0] dst_y,
  output logic [NP_W-1:0]    port_out
);
  import lar_pkg::*;

  localparam int unsigned NODES = MESH_X * MESH_Y;
  localparam int unsigned IDX_W = (NODES > 1) ? $clog2(NODES) : 1;

  logic     take_link;
  dir_idx_t dir;

  if (LINK_EN) begin : g_link
    logic [IDX_W-1:0] node_idx;
    logic             in_mesh;
    logic             at_near;
    always_comb begin
      in_mesh  = (int'(dst_x) < MESH_X) && (int'(dst_y) < MESH_Y);
      node_idx = IDX_W'(int'(dst_y) * MESH_X + int'(dst_x));
      at_near  = (hop_x == COORD_W'(NEAR_X)) && (hop_y == COORD_W'(NEAR_Y));
      take_link = at_near && in_mesh && SERVED[node_idx] &&
                  !((dst_x == hop_x) && (dst_y == hop_y));
    end
  end else begin : g_nolink
    assign take_link = 1'b0;
  end

  always_comb begin
    if (hop_is_local) begin
      dir = dir_idx_t'(DIR_LOCAL);
    end else if (take_link) begin
      dir = dir_idx_t'(DIR_LINK);
    end else if (dst_x > hop_x) begin
      dir = dir_idx_t'(DIR_EAST);
    end else if (dst_x < hop_x) begin
      dir = dir_idx_t'(DIR_WEST);
    end else if (dst_y > hop_y) begin
      dir = dir_idx_t'(DIR_NORTH);
    end else if (dst_y < hop_y) begin
      dir = dir_idx_t'(DIR_SOUTH);
    end else begin
      dir = dir_idx_t'(DIR_LOCAL);
    end
    port_out = NP_W'(1) << dir;
  end
endmodule

// File: rtl/lar_route_unit.sv
module lar_route_unit #(
  parameter int unsigned COORD_W   = 3,
  parameter int unsigned MESH_X    = 4,
  parameter int unsigned MESH_Y    = 4,
  parameter int unsigned PAYLOAD_W = 16,
  parameter bit          LINK_EN   = 1'b1,
  parameter int unsigned NEAR_X    = 0,
  parameter int unsigned NEAR_Y    = 0,
  parameter int unsigned FAR_X     = 3,
  parameter int unsigned FAR_Y     = 3,
  parameter logic [MESH_X*MESH_Y-1:0] SERVED = 16'hC800,
  localparam int unsigned NP_W     = LINK_EN ? 6 : 5,
  localparam int unsigned FLIT_W   = 2 * COORD_W + NP_W + PAYLOAD_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [COORD_W-1:0] my_x,
  input  logic [COORD_W-1:0] my_y,
  input  logic               in_valid,
  input  logic [FLIT_W-1:0]  in_flit,
  output logic               out_valid,
  output logic [FLIT_W-1:0]  out_flit
);
  localparam int unsigned DY_LSB   = 0;
  localparam int unsigned DX_LSB   = COORD_W;
  localparam int unsigned PORT_LSB = 2 * COORD_W;

  logic [COORD_W-1:0] hop_x, hop_y;
  logic               hop_is_local;
  logic [NP_W-1:0]    new_port;
  logic [FLIT_W-1:0]  flit_d;
  logic               valid_d;

  lar_next_hop #(
    .COORD_W(COORD_W), .NP_W(NP_W), .LINK_EN(LINK_EN),
    .FAR_X(FAR_X), .FAR_Y(FAR_Y)
  ) u_hop (
    .cur_x       (my_x),
    .cur_y       (my_y),
    .port_in     (in_flit[PORT_LSB +: NP_W]),
    .hop_x       (hop_x),
    .hop_y       (hop_y),
    .hop_is_local(hop_is_local)
  );

  lar_xy_pick #(
    .COORD_W(COORD_W), .NP_W(NP_W), .MESH_X(MESH_X), .MESH_Y(MESH_Y),
    .LINK_EN(LINK_EN), .NEAR_X(NEAR_X), .NEAR_Y(NEAR_Y), .SERVED(SERVED)
  ) u_pick (
    .hop_x       (hop_x),
    .hop_y       (hop_y),
    .hop_is_local(hop_is_local),
    .dst_x       (in_flit[DX_LSB +: COORD_W]),
    .dst_y       (in_flit[DY_LSB +: COORD_W]),
    .port_out    (new_port)
  );

  // next-state: rewrite only the next-port field
  always_comb begin
    flit_d                     = in_flit;
    flit_d[PORT_LSB +: NP_W]   = new_port;
    valid_d                    = in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_flit <= '0;
    end else if (in_valid) begin
      out_flit <= flit_d;
    end
  end
endmodule

// File: rtl/lar_route_checker.sv
module lar_route_checker #(
  parameter int unsigned FLIT_W   = 29,
  parameter int unsigned NP_W     = 6,
  parameter int unsigned PORT_LSB = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [FLIT_W-1:0] in_flit,
  input logic              out_valid,
  input logic [FLIT_W-1:0] out_flit
);
  localparam logic [FLIT_W-1:0] KEEP =
    ~({{(FLIT_W-NP_W){1'b0}}, {NP_W{1'b1}}} << PORT_LSB);

  a_r2_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r2_fields_kept: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ((out_flit & KEEP) == ($past(in_flit) & KEEP)));

  a_r3_port_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(out_flit[PORT_LSB +: NP_W]) == 1));

  a_r10_local_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_flit[PORT_LSB]) |=> (out_flit[PORT_LSB +: NP_W] == NP_W'(1)));

  a_r11_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_flit));
endmodule

bind lar_route_unit lar_route_checker #(
  .FLIT_W(FLIT_W), .NP_W(NP_W), .PORT_LSB(PORT_LSB)
) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_flit  (in_flit),
  .out_valid(out_valid),
  .out_flit (out_flit)
);

// File: tb/test_lar_route_unit.sv
module test_lar_route_unit;
  localparam int unsigned CW = 3;
  localparam int unsigned PW = 16;
  localparam int unsigned NP = 6;
  localparam int unsigned FW = 2 * CW + NP + PW + 1;

  localparam int D_L = 0, D_N = 1, D_E = 2, D_S = 3, D_W = 4, D_K = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [CW-1:0] my_x, my_y;
  logic          in_valid;
  logic [FW-1:0] in_flit;
  logic          out_valid;
  logic [FW-1:0] out_flit;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lar_route_unit i_lar_route_unit (
    .clk(clk), .rst_n(rst_n), .my_x(my_x), .my_y(my_y),
    .in_valid(in_valid), .in_flit(in_flit),
    .out_valid(out_valid), .out_flit(out_flit)
  );

  function automatic logic [FW-1:0] mk(int pdir, int dx, int dy, int pay, bit tl);
    logic [NP-1:0] p;
    p = NP'(1) << pdir;
    return {tl, PW'(pay), p, CW'(dx), CW'(dy)};
  endfunction

  task automatic chk(string req, logic [FW-1:0] act, logic [FW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // called at a falling edge; presents one flit and checks it one edge later
  task automatic route_case(string req, int mx, int my, int pdir,
                            int dx, int dy, int pay, bit tl, int exp_dir);
    my_x     = CW'(mx);
    my_y     = CW'(my);
    in_valid = 1'b1;
    in_flit  = mk(pdir, dx, dy, pay, tl);
    @(negedge clk);
    chk({req, " valid"}, FW'(out_valid), FW'(1));
    chk(req, out_flit, mk(exp_dir, dx, dy, pay, tl));
  endtask

  task automatic go_idle();
    in_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 out_valid in reset", FW'(out_valid), FW'(0));
    chk("R1 out_flit in reset", out_flit, '0);
  endtask

  task automatic t_x_first();
    route_case("R5 R4 east step then east", 1, 1, D_E, 3, 2, 16'h1234, 1'b0, D_E);
    route_case("R5 R4 north step then west", 2, 2, D_N, 0, 0, 16'hBEEF, 1'b1, D_W);
    go_idle();
  endtask

  task automatic t_y_then();
    route_case("R6 R4 east step then north", 1, 0, D_E, 2, 3, 16'h0F0F, 1'b0, D_N);
    route_case("R6 R4 south step then south", 3, 3, D_S, 3, 0, 16'hA5A5, 1'b1, D_S);
    go_idle();
  endtask

  task automatic t_local();
    route_case("R7 R4 west step reaches dest", 1, 2, D_W, 0, 2, 16'h7777, 1'b1, D_L);
    route_case("R10 incoming local kept", 1, 1, D_L, 3, 3, 16'h0001, 1'b0, D_L);
    go_idle();
  endtask

  task automatic t_link_hop();
    // far end of the link is (3,3)
    route_case("R4 link step to far end, dest there", 0, 0, D_K, 3, 3, 16'h4242, 1'b1, D_L);
    route_case("R4 link step to far end, then south", 0, 0, D_K, 3, 1, 16'h4343, 1'b0, D_S);
    go_idle();
  endtask

  task automatic t_link_choice();
    // near end (0,0); served destinations (3,3) (2,3) (3,2)
    route_case("R8 served (3,3) via link", 1, 0, D_W, 3, 3, 16'h1111, 1'b0, D_K);
    route_case("R8 served (2,3) via link", 0, 1, D_S, 2, 3, 16'h2222, 1'b1, D_K);
    route_case("R9 unserved from near end", 0, 1, D_S, 3, 1, 16'h3333, 1'b0, D_E);
    route_case("R9 served dest, not near end", 1, 1, D_E, 3, 3, 16'h4444, 1'b0, D_E);
    go_idle();
  endtask

  task automatic t_hold();
    logic [FW-1:0] last;
    route_case("R2 flit before idle", 2, 1, D_W, 1, 3, 16'h9999, 1'b1, D_N);
    last = out_flit;
    in_valid = 1'b0;
    in_flit  = mk(D_E, 0, 0, 16'hDEAD, 1'b0);
    @(negedge clk);
    chk("R11 valid drops when idle", FW'(out_valid), FW'(0));
    repeat (2) @(negedge clk);
    chk("R11 flit held while idle", out_flit, last);
  endtask

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_flit  = '0;
    my_x     = '0;
    my_y     = '0;
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_x_first();
    t_y_then();
    t_local();
    t_link_hop();
    t_link_choice();
    t_hold();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule